// File: doc/BRIEF.md
# Event Acceptance Control

This block sits in each digitizer channel and decides whether a detected pulse is kept as an event. It delays the channel's own fast trigger by a programmable number of cycles. The delay lets external validation signals, which arrive late, overlap it. On the rising edge of the delayed copy, the block weighs three things: the open validation windows, a combined veto and a pileup flag. From that it produces either an accept strobe, which starts trace storage and header writing downstream, or a reject strobe.

The module validation and channel validation signals are each chosen from a set of candidate lines or a front-panel gate input. Each is then widened by its own retriggerable stretcher. The veto is the OR of a module part and a channel part. Each part is enabled separately, and each takes either its validation source or its front-panel gate. The OR is widened by a third stretcher.

After an accept, the block ignores further fast triggers until the downstream writer has raised and then dropped its busy line. During that time, the first rising edge of the constant-fraction timing trigger gives a single strobe, which latches the timestamp and starts the trace.

Top module: `evt_accept_ctrl`

## Requirements
- R1: A rising edge on `fast_trig_i` first sampled at clock edge e is evaluated at edge e+`cfg_dly_i`+1. The accept or reject strobe is high during the cycle that follows that edge, and no earlier.
- R2: Each stretcher window is high at edges j+1 through j+L, where j is the last edge at which its input was sampled high and L is its 10-bit length. Fresh input restarts the count. With L = 0 the window never opens.
- R3: A module validation select value k below MVAL_N picks `mval_cand_i[k]`. The value MVAL_N picks `mod_gate_i`. Any larger value picks constant low.
- R4: Channel validation selection follows the same rule over `cval_cand_i`, with the value CVAL_N picking `chan_gate_i`. That same port also feeds the channel veto.
- R5: A validation requirement whose enable is low counts as met. When the enable is high, its window must be high at the decision edge.
- R6: The veto input is the OR of two parts. The module part is enabled by `cfg_mveto_en_i` and takes `mod_gate_i` when `cfg_mveto_gate_i` = 1, otherwise the selected module validation source. The channel part is enabled by `cfg_cveto_en_i` and takes `chan_gate_i` when `cfg_cveto_gate_i` = 1, otherwise the selected channel validation source. Accept requires the stretched veto window to be low.
- R7: A high `pileup_i` at the decision edge forces a reject.
- R8: Accept and reject are one-cycle pulses, never high together. Exactly one of them follows each fast trigger edge evaluated while armed.
- R9: After an accept, fast trigger edges give neither strobe until `busy_i` has been sampled high and later sampled low. The block is armed again from the edge after that low sample.
- R10: While not armed after an accept, the first rising edge of `cfd_trig_i` gives a one-cycle `stamp_o` pulse in the cycle after it is sampled. Later edges, and edges seen while armed, give none.
- R11: Synchronous reset clears all strobes, closes every window, empties the delay line and arms the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_trig_i | input | 1 | Channel local fast trigger, before delay |
| cfd_trig_i | input | 1 | Constant-fraction timing trigger |
| mval_cand_i | input | MVAL_N | Module validation candidate lines |
| mod_gate_i | input | 1 | Front-panel module gate |
| cval_cand_i | input | CVAL_N | Channel validation candidate lines |
| chan_gate_i | input | 1 | Front-panel channel gate (validation and veto) |
| pileup_i | input | 1 | Pileup flag from the trigger filter |
| busy_i | input | 1 | Downstream writer busy |
| cfg_dly_i | input | DLY_W | Fast trigger delay in cycles, minus one |
| cfg_mval_sel_i | input | MSEL_W | Module validation source select |
| cfg_cval_sel_i | input | CSEL_W | Channel validation source select |
| cfg_mval_en_i | input | 1 | Require module validation |
| cfg_cval_en_i | input | 1 | Require channel validation |
| cfg_mveto_en_i | input | 1 | Enable module veto part |
| cfg_mveto_gate_i | input | 1 | Module veto from gate (1) or validation source (0) |
| cfg_cveto_en_i | input | 1 | Enable channel veto part |
| cfg_cveto_gate_i | input | 1 | Channel veto from gate (1) or validation source (0) |
| cfg_mval_len_i | input | LEN_W | Module validation stretch length |
| cfg_cval_len_i | input | LEN_W | Channel validation stretch length |
| cfg_veto_len_i | input | LEN_W | Veto stretch length |
| acc_o | output | 1 | Record-accept strobe |
| rej_o | output | 1 | Reject strobe |
| stamp_o | output | 1 | Timestamp latch / trace start strobe |

## Verification
The properties assume that `busy_i` rises only after an accept and falls before the block could accept again. No strobe is checked against a busy line held high while the block is armed. They also assume that the stretch lengths and the delay change only across a reset, so that a window or the delay tap is never measured against a value different from the one it was loaded with.

The stimulus keeps to both assumptions in two ways. A small writer model raises busy one to three cycles after each accept and holds it for a random span. Every random segment reprograms the lengths, delay and selects under reset, and then drives sparse random pulses on all trigger, gate, pileup and timing lines.

// File: rtl/evt_acc_pkg.sv
package evt_acc_pkg;

  typedef enum logic [1:0] {
    ST_ARMED     = 2'd0,
    ST_WAIT_BUSY = 2'd1,
    ST_WAIT_IDLE = 2'd2
  } acc_state_e;

  localparam int NUM_WIN  = 3;
  localparam int WIN_MOD  = 0;
  localparam int WIN_CHAN = 1;
  localparam int WIN_VETO = 2;

endpackage

// File: rtl/evt_src_pick.sv
module evt_src_pick #(
  parameter int N     = 4,
  parameter int SEL_W = 3
) (
  input  logic [N-1:0]     cand_i,
  input  logic             gate_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pick_o
);

  // Index below N picks a candidate, index N picks the gate, anything above is low.
  always_comb begin
    pick_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (sel_i == SEL_W'(k)) pick_o = cand_i[k];
    end
    if (sel_i == SEL_W'(N)) pick_o = gate_i;
  end

endmodule

// File: rtl/evt_stretch.sv
module evt_stretch #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             win_o
);

  logic [LEN_W-1:0] remain_q;

  // Retriggerable: every sampled high reloads the full length.
  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (trig_i) begin
      remain_q <= len_i;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - LEN_W'(1);
    end
  end

  assign win_o = (remain_q != '0);

endmodule

// File: rtl/evt_fast_delay.sv
module evt_fast_delay #(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             dly_o,
  output logic             prev_o
);

  localparam int DEPTH = 1 << DLY_W;

  logic [DEPTH-1:0] line_q;
  logic             prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      prev_q <= 1'b0;
    end else begin
      line_q <= {line_q[DEPTH-2:0], trig_i};
      prev_q <= line_q[dly_i];
    end
  end

  assign dly_o  = line_q[dly_i];
  assign prev_o = prev_q;

endmodule

// File: rtl/evt_decide.sv
module evt_decide
  import evt_acc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ft_dly_i,
  input  logic ft_prev_i,
  input  logic mval_win_i,
  input  logic cval_win_i,
  input  logic veto_win_i,
  input  logic mval_en_i,
  input  logic cval_en_i,
  input  logic pileup_i,
  input  logic busy_i,
  input  logic cfd_i,
  output logic acc_o,
  output logic rej_o,
  output logic stamp_o
);

  acc_state_e state_q;
  logic       stamped_q;
  logic       cfd_q;
  logic       fire;
  logic       pass;
  logic       cfd_rise;

  always_comb begin
    fire     = ft_dly_i & ~ft_prev_i;
    pass     = (~mval_en_i | mval_win_i) & (~cval_en_i | cval_win_i) &
               ~veto_win_i & ~pileup_i;
    cfd_rise = cfd_i & ~cfd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_ARMED;
      stamped_q <= 1'b0;
      cfd_q     <= 1'b0;
      acc_o     <= 1'b0;
      rej_o     <= 1'b0;
      stamp_o   <= 1'b0;
    end else begin
      acc_o   <= 1'b0;
      rej_o   <= 1'b0;
      stamp_o <= 1'b0;
      cfd_q   <= cfd_i;
      if (state_q != ST_ARMED && cfd_rise && !stamped_q) begin
        stamp_o   <= 1'b1;
        stamped_q <= 1'b1;
      end
      case (state_q)
        ST_ARMED: begin
          if (fire) begin
            if (pass) begin
              acc_o     <= 1'b1;
              stamped_q <= 1'b0;
              state_q   <= ST_WAIT_BUSY;
            end else begin
              rej_o <= 1'b1;
            end
          end
        end
        ST_WAIT_BUSY: if (busy_i)  state_q <= ST_WAIT_IDLE;
        ST_WAIT_IDLE: if (!busy_i) state_q <= ST_ARMED;
        default:                   state_q <= ST_ARMED;
      endcase
    end
  end

endmodule

// File: rtl/evt_accept_ctrl.sv
module evt_accept_ctrl
  import evt_acc_pkg::*;
#(
  parameter int MVAL_N = 4,
  parameter int CVAL_N = 4,
  parameter int LEN_W  = 10,
  parameter int DLY_W  = 6,
  localparam int MSEL_W = $clog2(MVAL_N + 1),
  localparam int CSEL_W = $clog2(CVAL_N + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fast_trig_i,
  input  logic              cfd_trig_i,
  input  logic [MVAL_N-1:0] mval_cand_i,
  input  logic              mod_gate_i,
  input  logic [CVAL_N-1:0] cval_cand_i,
  input  logic              chan_gate_i,
  input  logic              pileup_i,
  input  logic              busy_i,
  input  logic [DLY_W-1:0]  cfg_dly_i,
  input  logic [MSEL_W-1:0] cfg_mval_sel_i,
  input  logic [CSEL_W-1:0] cfg_cval_sel_i,
  input  logic              cfg_mval_en_i,
  input  logic              cfg_cval_en_i,
  input  logic              cfg_mveto_en_i,
  input  logic              cfg_mveto_gate_i,
  input  logic              cfg_cveto_en_i,
  input  logic              cfg_cveto_gate_i,
  input  logic [LEN_W-1:0]  cfg_mval_len_i,
  input  logic [LEN_W-1:0]  cfg_cval_len_i,
  input  logic [LEN_W-1:0]  cfg_veto_len_i,
  output logic              acc_o,
  output logic              rej_o,
  output logic              stamp_o
);

  logic             mval_raw;
  logic             cval_raw;
  logic             veto_raw;
  logic             mval_win;
  logic             cval_win;
  logic             veto_win;
  logic             ft_dly;
  logic             ft_prev;
  logic [NUM_WIN-1:0] win_in;
  logic [NUM_WIN-1:0] win_q;
  logic [LEN_W-1:0]   win_len [NUM_WIN];

  evt_src_pick #(.N(MVAL_N), .SEL_W(MSEL_W)) u_mval_pick (
    .cand_i (mval_cand_i),
    .gate_i (mod_gate_i),
    .sel_i  (cfg_mval_sel_i),
    .pick_o (mval_raw)
  );

  evt_src_pick #(.N(CVAL_N), .SEL_W(CSEL_W)) u_cval_pick (
    .cand_i (cval_cand_i),
    .gate_i (chan_gate_i),
    .sel_i  (cfg_cval_sel_i),
    .pick_o (cval_raw)
  );

  // Veto parts: each enabled on its own, each taking gate or validation source.
  always_comb begin
    veto_raw = (cfg_mveto_en_i & (cfg_mveto_gate_i ? mod_gate_i  : mval_raw)) |
               (cfg_cveto_en_i & (cfg_cveto_gate_i ? chan_gate_i : cval_raw));
  end

  always_comb begin
    win_in[WIN_MOD]   = mval_raw;
    win_in[WIN_CHAN]  = cval_raw;
    win_in[WIN_VETO]  = veto_raw;
    win_len[WIN_MOD]  = cfg_mval_len_i;
    win_len[WIN_CHAN] = cfg_cval_len_i;
    win_len[WIN_VETO] = cfg_veto_len_i;
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    evt_stretch #(.LEN_W(LEN_W)) u_stretch (
      .clk    (clk),
      .rst    (rst),
      .trig_i (win_in[g]),
      .len_i  (win_len[g]),
      .win_o  (win_q[g])
    );
  end

  assign mval_win = win_q[WIN_MOD];
  assign cval_win = win_q[WIN_CHAN];
  assign veto_win = win_q[WIN_VETO];

  evt_fast_delay #(.DLY_W(DLY_W)) u_delay (
    .clk    (clk),
    .rst    (rst),
    .trig_i (fast_trig_i),
    .dly_i  (cfg_dly_i),
    .dly_o  (ft_dly),
    .prev_o (ft_prev)
  );

  evt_decide u_decide (
    .clk        (clk),
    .rst        (rst),
    .ft_dly_i   (ft_dly),
    .ft_prev_i  (ft_prev),
    .mval_win_i (mval_win),
    .cval_win_i (cval_win),
    .veto_win_i (veto_win),
    .mval_en_i  (cfg_mval_en_i),
    .cval_en_i  (cfg_cval_en_i),
    .pileup_i   (pileup_i),
    .busy_i     (busy_i),
    .cfd_i      (cfd_trig_i),
    .acc_o      (acc_o),
    .rej_o      (rej_o),
    .stamp_o    (stamp_o)
  );

endmodule

// File: rtl/evt_accept_ctrl_chk.sv
module evt_accept_ctrl_chk #(
  parameter int LEN_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_o,
  input logic             rej_o,
  input logic             stamp_o,
  input logic             busy_i,
  input logic             pileup_i,
  input logic             ft_dly,
  input logic             mval_win,
  input logic             cval_win,
  input logic             veto_win,
  input logic             mval_raw,
  input logic             veto_raw,
  input logic             cfg_mval_en_i,
  input logic             cfg_cval_en_i,
  input logic [LEN_W-1:0] cfg_mval_len_i,
  input logic [LEN_W-1:0] cfg_veto_len_i
);

  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(acc_o && rej_o));

  p_acc_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    acc_o |=> !acc_o);

  p_on_edge_r1: assert property (@(posedge clk) disable iff (rst)
    (acc_o || rej_o) |-> ($past(ft_dly) && !$past(ft_dly, 2)));

  p_mval_r5: assert property (@(posedge clk) disable iff (rst)
    acc_o |-> (!$past(cfg_mval_en_i) || $past(mval_win)));

  p_cval_r5: assert property (@(posedge clk) disable iff (rst)
    acc_o |-> (!$past(cfg_cval_en_i) || $past(cval_win)));

  p_veto_r6: assert property (@(posedge clk) disable iff (rst)
    acc_o |-> !$past(veto_win));

  p_pileup_r7: assert property (@(posedge clk) disable iff (rst)
    acc_o |-> !$past(pileup_i));

  p_mstretch_r2: assert property (@(posedge clk) disable iff (rst)
    (mval_raw && cfg_mval_len_i != '0) |=> mval_win);

  p_vstretch_r2: assert property (@(posedge clk) disable iff (rst)
    (veto_raw && cfg_veto_len_i != '0) |=> veto_win);

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> !acc_o);

  p_stamp_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    stamp_o |=> !stamp_o);

endmodule

bind evt_accept_ctrl evt_accept_ctrl_chk #(.LEN_W(LEN_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .acc_o          (acc_o),
  .rej_o          (rej_o),
  .stamp_o        (stamp_o),
  .busy_i         (busy_i),
  .pileup_i       (pileup_i),
  .ft_dly         (ft_dly),
  .mval_win       (mval_win),
  .cval_win       (cval_win),
  .veto_win       (veto_win),
  .mval_raw       (mval_raw),
  .veto_raw       (veto_raw),
  .cfg_mval_en_i  (cfg_mval_en_i),
  .cfg_cval_en_i  (cfg_cval_en_i),
  .cfg_mval_len_i (cfg_mval_len_i),
  .cfg_veto_len_i (cfg_veto_len_i)
);

// File: tb/evt_accept_ctrl_tb.sv
module evt_accept_ctrl_tb;

  localparam int MN = 4;
  localparam int CN = 4;
  localparam int LW = 10;
  localparam int DW = 6;
  localparam int HN = 4096;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fast_trig = 1'b0, cfd_trig = 1'b0;
  logic [MN-1:0] mval_cand = '0;
  logic [CN-1:0] cval_cand = '0;
  logic          mod_gate = 1'b0, chan_gate = 1'b0, pileup = 1'b0, busy = 1'b0;
  logic [DW-1:0] cfg_dly = '0;
  logic [2:0]    cfg_mval_sel = '0, cfg_cval_sel = '0;
  logic          cfg_mval_en = 1'b0, cfg_cval_en = 1'b0;
  logic          cfg_mveto_en = 1'b0, cfg_mveto_gate = 1'b0;
  logic          cfg_cveto_en = 1'b0, cfg_cveto_gate = 1'b0;
  logic [LW-1:0] cfg_mval_len = 10'd8, cfg_cval_len = 10'd8, cfg_veto_len = 10'd4;
  logic          acc_o, rej_o, stamp_o;

  int n_chk = 0;
  int n_err = 0;

  // reference model state
  int t_m;
  bit hist [HN];
  int mv_last, cv_last, vt_last;
  int m_state;
  bit m_stamped, m_cfd_q, m_acc, m_rej, m_stamp;
  int wr_pend, wr_len;

  always #10 clk = ~clk;

  evt_accept_ctrl #(.MVAL_N(MN), .CVAL_N(CN), .LEN_W(LW), .DLY_W(DW)) u_dut (
    .clk(clk), .rst(rst), .fast_trig_i(fast_trig), .cfd_trig_i(cfd_trig),
    .mval_cand_i(mval_cand), .mod_gate_i(mod_gate), .cval_cand_i(cval_cand),
    .chan_gate_i(chan_gate), .pileup_i(pileup), .busy_i(busy),
    .cfg_dly_i(cfg_dly), .cfg_mval_sel_i(cfg_mval_sel), .cfg_cval_sel_i(cfg_cval_sel),
    .cfg_mval_en_i(cfg_mval_en), .cfg_cval_en_i(cfg_cval_en),
    .cfg_mveto_en_i(cfg_mveto_en), .cfg_mveto_gate_i(cfg_mveto_gate),
    .cfg_cveto_en_i(cfg_cveto_en), .cfg_cveto_gate_i(cfg_cveto_gate),
    .cfg_mval_len_i(cfg_mval_len), .cfg_cval_len_i(cfg_cval_len),
    .cfg_veto_len_i(cfg_veto_len),
    .acc_o(acc_o), .rej_o(rej_o), .stamp_o(stamp_o)
  );

  function automatic bit pick(logic [3:0] cand, logic gate, int sel, int n);
    if (sel < n)  return cand[sel];
    if (sel == n) return gate;
    return 1'b0;
  endfunction

  function automatic bit in_win(int last, int now, int len);
    int diff = now - last;
    return (diff >= 1) && (diff <= len);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    t_m = 0;
    for (int i = 0; i < HN; i++) hist[i] = 1'b0;
    mv_last = -1000000; cv_last = -1000000; vt_last = -1000000;
    m_state = 0; m_stamped = 0; m_cfd_q = 0;
    m_acc = 0; m_rej = 0; m_stamp = 0;
  endtask

  // Advance the model by one clock edge using the inputs now applied.
  task automatic model_edge();
    int d = int'(cfg_dly);
    bit ftd, ftp, mw, cw, vw, ok, mr, cr, vr;
    ftd = (t_m - 1 - d >= 0) ? hist[t_m - 1 - d] : 1'b0;
    ftp = (t_m - 2 - d >= 0) ? hist[t_m - 2 - d] : 1'b0;
    mw  = in_win(mv_last, t_m, int'(cfg_mval_len));
    cw  = in_win(cv_last, t_m, int'(cfg_cval_len));
    vw  = in_win(vt_last, t_m, int'(cfg_veto_len));
    ok  = (!cfg_mval_en || mw) && (!cfg_cval_en || cw) && !vw && !pileup;
    m_acc = 0; m_rej = 0; m_stamp = 0;
    if (m_state != 0 && cfd_trig && !m_cfd_q && !m_stamped) begin
      m_stamp = 1; m_stamped = 1;
    end
    case (m_state)
      0: if (ftd && !ftp) begin
           if (ok) begin m_acc = 1; m_state = 1; m_stamped = 0; end
           else m_rej = 1;
         end
      1: if (busy)  m_state = 2;
      default: if (!busy) m_state = 0;
    endcase
    mr = pick(mval_cand, mod_gate, int'(cfg_mval_sel), MN);
    cr = pick(cval_cand, chan_gate, int'(cfg_cval_sel), CN);
    vr = (cfg_mveto_en && (cfg_mveto_gate ? mod_gate : mr)) ||
         (cfg_cveto_en && (cfg_cveto_gate ? chan_gate : cr));
    if (mr) mv_last = t_m;
    if (cr) cv_last = t_m;
    if (vr) vt_last = t_m;
    if (t_m < HN) hist[t_m] = fast_trig;
    m_cfd_q = cfd_trig;
    t_m++;
  endtask

  task automatic tick();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check("R1 R5 R6 R7 R8 R9 accept vs model", acc_o, m_acc);
    check("R7 R8 R9 reject vs model", rej_o, m_rej);
    check("R10 stamp vs model", stamp_o, m_stamp);
  endtask

  task automatic do_reset();
    fast_trig = 0; cfd_trig = 0; busy = 0; pileup = 0;
    mval_cand = '0; cval_cand = '0; mod_gate = 0; chan_gate = 0;
    rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
    check("R11 acc low after reset", acc_o, 0);
    check("R11 rej low after reset", rej_o, 0);
    check("R11 stamp low after reset", stamp_o, 0);
  endtask

  task automatic fire();
    fast_trig = 1; tick();
    fast_trig = 0; tick();
  endtask

  task automatic rearm();
    busy = 1; tick();
    busy = 0; tick();
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R9 actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);

    // R11: windows closed right after reset
    cfg_mval_en = 1;
    do_reset();
    fire();
    check("R11 R5 module window closed after reset", rej_o, 1);
    cfg_mval_en = 0;

    // R1: delay timing
    cfg_dly = 6'd5;
    do_reset();
    fast_trig = 1; tick(); fast_trig = 0;
    idle(5);
    check("R1 no strobe before delay", acc_o, 0);
    tick();
    check("R1 accept at delay+1", acc_o, 1);
    tick();
    check("R8 accept lasts one cycle", acc_o, 0);
    rearm();
    cfg_dly = '0;
    do_reset();

    // R9: hold until busy cycle
    fire();
    check("R9 first accept", acc_o, 1);
    idle(2);
    fire();
    check("R9 accept ignored while held", acc_o, 0);
    check("R9 reject ignored while held", rej_o, 0);
    rearm();
    fire();
    check("R9 accept after busy cycle", acc_o, 1);
    rearm();

    // R2: stretch boundaries
    cfg_mval_len = 10'd3; cfg_mval_en = 1; cfg_mval_sel = 3'd0;
    do_reset();
    mval_cand = 4'b0001; tick(); mval_cand = '0;
    tick();
    fast_trig = 1; tick(); fast_trig = 0; tick();
    check("R2 last cycle of window accepts", acc_o, 1);
    rearm(); idle(4);
    mval_cand = 4'b0001; tick(); mval_cand = '0;
    idle(2);
    fast_trig = 1; tick(); fast_trig = 0; tick();
    check("R2 window closed after L", rej_o, 1);
    idle(4);
    mval_cand = 4'b0001; tick(); mval_cand = '0; tick();
    mval_cand = 4'b0001; tick(); mval_cand = '0; tick();
    fast_trig = 1; tick(); fast_trig = 0; tick();
    check("R2 retrigger extends window", acc_o, 1);
    rearm();
    cfg_mval_len = '0;
    do_reset();
    mval_cand = 4'b0001;
    fire();
    check("R2 zero length never opens", rej_o, 1);
    mval_cand = '0;

    // R3 / R4: source selection
    cfg_mval_len = 10'd8; cfg_cval_len = 10'd8;
    do_reset();
    cfg_mval_sel = 3'd4;
    mod_gate = 1; tick(); mod_gate = 0;
    fire();
    check("R3 index MVAL_N picks module gate", acc_o, 1);
    rearm(); idle(10);
    cfg_mval_sel = 3'd6;
    mval_cand = 4'hF; mod_gate = 1; tick();
    fire();
    check("R3 out-of-range select is low", rej_o, 1);
    mval_cand = '0; mod_gate = 0; idle(10);
    cfg_mval_sel = 3'd2;
    mval_cand = 4'b1011; tick(); mval_cand = '0;
    fire();
    check("R3 unselected candidates ignored", rej_o, 1);
    idle(10);
    mval_cand = 4'b0100; tick(); mval_cand = '0;
    fire();
    check("R3 selected candidate passes", acc_o, 1);
    rearm(); idle(10);
    cfg_mval_en = 0; cfg_cval_en = 1; cfg_cval_sel = 3'd4;
    chan_gate = 1; tick(); chan_gate = 0;
    fire();
    check("R4 index CVAL_N picks channel gate", acc_o, 1);
    rearm(); idle(10);
    cfg_cval_sel = 3'd1;
    cval_cand = 4'b0010; tick(); cval_cand = '0;
    fire();
    check("R4 channel candidate passes", acc_o, 1);
    rearm(); idle(10);
    cfg_cval_en = 0;

    // R6: veto
    cfg_mveto_en = 1; cfg_mveto_gate = 1;
    mod_gate = 1; tick(); mod_gate = 0;
    fire();
    check("R6 module gate veto rejects", rej_o, 1);
    idle(6);
    fire();
    check("R6 veto expired accepts", acc_o, 1);
    rearm(); idle(10);
    cfg_mveto_en = 0;
    mod_gate = 1; tick(); mod_gate = 0;
    fire();
    check("R6 disabled module veto ignored", acc_o, 1);
    rearm(); idle(10);
    cfg_cveto_en = 1; cfg_cveto_gate = 0; cfg_cval_sel = 3'd1;
    cval_cand = 4'b0010; tick(); cval_cand = '0;
    fire();
    check("R6 channel veto from validation source", rej_o, 1);
    idle(6);
    cfg_cveto_en = 0;

    // R7: pileup
    pileup = 1;
    fire();
    check("R7 pileup rejects", rej_o, 1);
    pileup = 0;
    idle(2);

    // R10: stamp
    fire();
    check("R10 accept before stamp", acc_o, 1);
    cfd_trig = 1; tick();
    check("R10 first cfd edge stamps", stamp_o, 1);
    cfd_trig = 0; tick();
    cfd_trig = 1; tick();
    check("R10 second cfd edge ignored", stamp_o, 0);
    cfd_trig = 0;
    rearm();
    cfd_trig = 1; tick();
    check("R10 cfd while armed ignored", stamp_o, 0);
    cfd_trig = 0; tick();

    // constrained random segments
    for (int seg = 0; seg < 12; seg++) begin
      cfg_dly        = ($urandom % 4 == 0) ? DW'($urandom % 64) : DW'($urandom % 6);
      cfg_mval_len   = LW'($urandom % 16);
      cfg_cval_len   = LW'($urandom % 16);
      cfg_veto_len   = LW'($urandom % 8);
      cfg_mval_sel   = 3'($urandom % 8);
      cfg_cval_sel   = 3'($urandom % 8);
      cfg_mval_en    = 1'($urandom);
      cfg_cval_en    = 1'($urandom);
      cfg_mveto_en   = ($urandom % 3 == 0);
      cfg_mveto_gate = 1'($urandom);
      cfg_cveto_en   = ($urandom % 3 == 0);
      cfg_cveto_gate = 1'($urandom);
      do_reset();
      wr_pend = 0; wr_len = 0;
      for (int c = 0; c < 600; c++) begin
        fast_trig = ($urandom % 100) < 10;
        cfd_trig  = ($urandom % 100) < 20;
        mval_cand = (($urandom % 100) < 15) ? MN'($urandom) : '0;
        cval_cand = (($urandom % 100) < 15) ? CN'($urandom) : '0;
        mod_gate  = ($urandom % 100) < 6;
        chan_gate = ($urandom % 100) < 6;
        pileup    = ($urandom % 100) < 10;
        if (wr_pend > 0) begin
          wr_pend--;
          if (wr_pend == 0) begin
            busy = 1; wr_len = 1 + int'($urandom % 6);
          end
        end else if (busy) begin
          wr_len--;
          if (wr_len == 0) busy = 0;
        end
        tick();
        if (m_acc) wr_pend = 1 + int'($urandom % 3);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule